// File: doc/BRIEF.md
# Multi-Core Local Interrupt Concentrator

This block collects every interrupt aimed at the cores of one cluster and turns them into one interrupt line per core. It handles three classes of source. Level hardware lines come straight from local peripherals. Mailbox interrupts are raised by any bus write to a mailbox word, which is how inter-processor interrupts and bridged external events arrive. The third class is one periodic countdown timer per core. Each core has its own mask for each class, so software decides which core services which source.

When a core takes an interrupt, its handler reads one packed status word. For each class, that word holds a valid flag and the index of the lowest-numbered source that is both active and enabled for that core. The handler then clears the source. For a mailbox it reads the mailbox word. For a timer it reads the acknowledge word. A hardware line is cleared at the peripheral itself. All registers sit behind a 32-bit word-addressed read/write port. Read data is registered. Reads of the mailbox and timer-acknowledge words have side effects.

Top module: `irq_concentrator`

## Requirements
- R1: The word address is {func[4:0], index[4:0]}. The function codes are:
  - 0: mailbox n
  - 1: timer period
  - 2: timer value
  - 3: timer acknowledge
  - 4, 8, 12: timer, hardware and mailbox mask
  - 5, 9, 13: their set words
  - 6, 10, 14: their clear words
  - 15: status
  - 16: configuration

  Per-core words use index as the core number. A per-core read with an index of NCORES or above returns 0.
- R2: A write to a set word ORs the written bitmask into that core's mask for that class. A write to a clear word removes the written bits. Other bits, other classes and other cores keep their values. Reading the mask word returns the mask.
- R3: core_irq[c] is high exactly when some source of any class is both active and enabled in core c's mask. Hardware bit i reflects hw_irq[i]. Timer mask bit k enables timer k.
- R4: The status word for core c reports each class separately:
  - timer: valid flag in bit 0, index in [12:8]
  - hardware: valid flag in bit 1, index in [20:16]
  - mailbox: valid flag in bit 2, index in [28:24]

  The index is the lowest active and enabled source of that class. All other bits are 0. A class with no such source has a 0 flag and a 0 index.
- R5: The configuration word returns the mailbox count in [23:16], the hardware count in [15:8] and the timer count in [7:0].
- R6: Any write to mailbox n (n < NWTI) stores the data and makes mailbox n pending. Writes to indexes NWTI or above are ignored. A read of mailbox n returns the data held before that cycle and clears the pending flag. When a write and a read hit the same mailbox in one cycle, the flag stays set.
- R7: Writing period P to timer c loads its value with P. From then on the value counts down once per cycle. In the cycle where the value is at most 1, it reloads P and timer c becomes pending, so the timer fires every P cycles. Period 0 stops the timer and clears its value. The period and value words read back.
- R8: A read of timer c's acknowledge word clears its pending flag. If the timer fires in that same cycle, the flag stays set.
- R9: Reads of codes 6, 10 and 14 return the raw active bitmaps before masking: pending timers, the hw_irq lines and pending mailboxes.
- R10: Reset (rst_n low at a clock edge) clears all masks, pending flags, periods, timer values and read data.
- R11: Read data appears on bus_rdata in the cycle after bus_rd is asserted. It is 0 in every other cycle and for unused function codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq | input | NHWI | Level hardware interrupt lines, synchronous to clk |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Word address {func, index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_irq | output | NCORES | Interrupt line per core |

## Verification
Two functions can collide on one clock edge: a timer reaching the end of its count and software acknowledging that same timer. The bench programs a period of 5 and counts edges from the period write. It places the acknowledge read so that its edge is exactly the fifth edge after a reload. It then expects the core's line to stay high, while an acknowledge on any other edge must drop the line. The mailbox write and mailbox read are also issued in one cycle. There the bench expects the old data on the read port, a pending flag that stays set, and the new data on the next read.

// File: rtl/irq_conc_pkg.sv
// Package: shared function codes and field widths of the interrupt concentrator.
// Assumes a 10-bit word address split into a 5-bit function and a 5-bit index.
package irq_conc_pkg;
    localparam int FUNC_W = 5;
    localparam int IDX_W  = 5;
    localparam int ADDR_W = FUNC_W + IDX_W;

    typedef enum logic [FUNC_W-1:0] {
        FN_MBOX = 5'd0,
        FN_TPER = 5'd1,
        FN_TVAL = 5'd2,
        FN_TACK = 5'd3,
        FN_PMSK = 5'd4,
        FN_PSET = 5'd5,
        FN_PCLR = 5'd6,
        FN_HMSK = 5'd8,
        FN_HSET = 5'd9,
        FN_HCLR = 5'd10,
        FN_WMSK = 5'd12,
        FN_WSET = 5'd13,
        FN_WCLR = 5'd14,
        FN_PRIO = 5'd15,
        FN_CONF = 5'd16
    } func_e;
endpackage

// File: rtl/irq_conc_first.sv
// Lowest-index finder: reports whether any bit of vec is set and the index of
// the lowest set bit. Assumes N <= 32 so the index fits in five bits.
module irq_conc_first #(
    parameter int N = 8
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [4:0]   idx
);
    // scan from the top so the lowest set bit is the last one assigned
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = 5'(i);
        end
    end
endmodule

// File: rtl/irq_conc_timer.sv
// One periodic countdown timer with a pending flag. A write loads the period
// and the value. A nonzero period reloads and fires when the value is at most 1.
// A set caused by firing beats a clear from acknowledge.
module irq_conc_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             ack,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] value,
    output logic             pend
);
    logic fire;

    // expiry strobe: running, at end of count, not being reprogrammed
    assign fire = !per_we && (period != '0) && (value <= CNT_W'(1));

    // period register and down-counter with reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            value  <= '0;
        end else if (per_we) begin
            period <= per_wdata;
            value  <= per_wdata;
        end else if (period != '0) begin
            value <= fire ? period : value - CNT_W'(1);
        end
    end

    // pending flag: set on expiry, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (fire) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end
endmodule

// File: rtl/irq_concentrator.sv
// Per-cluster interrupt concentrator. Merges level hardware lines, write-set
// mailboxes and one timer per core behind per-core masks. Drives one line per
// core and returns a packed lowest-index status word per core.
// Assumes NHWI, NWTI and NCORES are each between 2 and 16, and that hw_irq is
// already synchronous to clk. Interrupt lines are combinational from state.
module irq_concentrator #(
    parameter int NCORES = 4,
    parameter int NHWI   = 8,
    parameter int NWTI   = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NHWI-1:0]   hw_irq,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [9:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCORES-1:0] core_irq
);
    import irq_conc_pkg::*;

    localparam int NPTI = NCORES;
    localparam int CW   = $clog2(NCORES);
    localparam int WW   = $clog2(NWTI);

    logic [FUNC_W-1:0] func;
    logic [IDX_W-1:0]  idx;
    logic              core_ok, mbox_ok;
    logic [CW-1:0]     csel;
    logic [WW-1:0]     wsel;

    logic [NCORES-1:0][NHWI-1:0] hmask_q;
    logic [NCORES-1:0][NWTI-1:0] wmask_q;
    logic [NCORES-1:0][NPTI-1:0] pmask_q;
    logic [NWTI-1:0]             wti_pend;
    logic [NWTI-1:0][31:0]       mbox_q;
    logic [NPTI-1:0]             pti_pend;
    logic [NPTI-1:0][CNT_W-1:0]  tmr_period;
    logic [NPTI-1:0][CNT_W-1:0]  tmr_value;
    logic [NCORES-1:0][31:0]     prio_word;
    logic [31:0]                 rd_mux;

    assign func    = bus_addr[9:5];
    assign idx     = bus_addr[4:0];
    assign core_ok = int'(idx) < NCORES;
    assign mbox_ok = int'(idx) < NWTI;
    assign csel    = idx[CW-1:0];
    assign wsel    = idx[WW-1:0];

    // per-core mask registers: set words OR in, clear words AND out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hmask_q <= '0;
            wmask_q <= '0;
            pmask_q <= '0;
        end else if (bus_wr) begin
            for (int c = 0; c < NCORES; c++) begin
                if (idx == IDX_W'(c)) begin
                    if (func == FN_HSET) hmask_q[c] <= hmask_q[c] | bus_wdata[NHWI-1:0];
                    if (func == FN_HCLR) hmask_q[c] <= hmask_q[c] & ~bus_wdata[NHWI-1:0];
                    if (func == FN_WSET) wmask_q[c] <= wmask_q[c] | bus_wdata[NWTI-1:0];
                    if (func == FN_WCLR) wmask_q[c] <= wmask_q[c] & ~bus_wdata[NWTI-1:0];
                    if (func == FN_PSET) pmask_q[c] <= pmask_q[c] | bus_wdata[NPTI-1:0];
                    if (func == FN_PCLR) pmask_q[c] <= pmask_q[c] & ~bus_wdata[NPTI-1:0];
                end
            end
        end
    end

    // mailboxes: one data word and one pending flag each
    for (genvar n = 0; n < NWTI; n++) begin : g_mbox
        logic mb_set, mb_clr;
        assign mb_set = bus_wr && (func == FN_MBOX) && (idx == IDX_W'(n));
        assign mb_clr = bus_rd && (func == FN_MBOX) && (idx == IDX_W'(n));

        // data capture and pending flag, with set beating clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mbox_q[n]   <= '0;
                wti_pend[n] <= 1'b0;
            end else begin
                if (mb_set) mbox_q[n] <= bus_wdata;
                if (mb_set)      wti_pend[n] <= 1'b1;
                else if (mb_clr) wti_pend[n] <= 1'b0;
            end
        end
    end

    // one timer per core
    for (genvar c = 0; c < NPTI; c++) begin : g_tmr
        irq_conc_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .per_we   (bus_wr && (func == FN_TPER) && (idx == IDX_W'(c))),
            .per_wdata(bus_wdata[CNT_W-1:0]),
            .ack      (bus_rd && (func == FN_TACK) && (idx == IDX_W'(c))),
            .period   (tmr_period[c]),
            .value    (tmr_value[c]),
            .pend     (pti_pend[c])
        );
    end

    // per-core priority encoding and interrupt line
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic       h_hit, w_hit, p_hit;
        logic [4:0] h_idx, w_idx, p_idx;
        logic [NHWI-1:0] h_act;
        logic [NWTI-1:0] w_act;
        logic [NPTI-1:0] p_act;

        assign h_act = hw_irq & hmask_q[c];
        assign w_act = wti_pend & wmask_q[c];
        assign p_act = pti_pend & pmask_q[c];

        irq_conc_first #(.N(NHWI)) u_h (.vec(h_act), .hit(h_hit), .idx(h_idx));
        irq_conc_first #(.N(NWTI)) u_w (.vec(w_act), .hit(w_hit), .idx(w_idx));
        irq_conc_first #(.N(NPTI)) u_p (.vec(p_act), .hit(p_hit), .idx(p_idx));

        assign prio_word[c] = {3'b0, w_idx, 3'b0, h_idx, 3'b0, p_idx,
                               5'b0, w_hit, h_hit, p_hit};
        assign core_irq[c]  = (|h_act) | (|w_act) | (|p_act);
    end

    // read multiplexer by function code
    always_comb begin
        rd_mux = '0;
        case (func)
            FN_MBOX: if (mbox_ok) rd_mux = mbox_q[wsel];
            FN_TPER: if (core_ok) rd_mux = 32'(tmr_period[csel]);
            FN_TVAL: if (core_ok) rd_mux = 32'(tmr_value[csel]);
            FN_PMSK: if (core_ok) rd_mux = 32'(pmask_q[csel]);
            FN_HMSK: if (core_ok) rd_mux = 32'(hmask_q[csel]);
            FN_WMSK: if (core_ok) rd_mux = 32'(wmask_q[csel]);
            FN_PRIO: if (core_ok) rd_mux = prio_word[csel];
            FN_PCLR: rd_mux = 32'(pti_pend);
            FN_HCLR: rd_mux = 32'(hw_irq);
            FN_WCLR: rd_mux = 32'(wti_pend);
            FN_CONF: rd_mux = {8'd0, 8'(NWTI), 8'(NHWI), 8'(NPTI)};
            default: rd_mux = '0;
        endcase
    end

    // registered read data, zero outside read responses
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_rd ? rd_mux : '0;
    end
endmodule

// File: rtl/irq_conc_chk.sv
// Checker for the interrupt concentrator, attached by bind. Relates bus
// strobes to mask, pending and timer state, and relates the status word to
// the interrupt lines.
module irq_conc_chk #(
    parameter int NCORES = 4,
    parameter int NHWI   = 8,
    parameter int NWTI   = 8,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [9:0]                   bus_addr,
    input logic [31:0]                  bus_wdata,
    input logic [31:0]                  bus_rdata,
    input logic [NCORES-1:0]            core_irq,
    input logic [NCORES-1:0][NHWI-1:0]  hmask,
    input logic [NWTI-1:0]              wti_pend,
    input logic [NCORES-1:0]            pti_pend,
    input logic [NCORES-1:0][31:0]      prio_word,
    input logic [NCORES-1:0][CNT_W-1:0] tmr_period,
    input logic [NCORES-1:0][CNT_W-1:0] tmr_value
);
    // R11: read data is zero in the cycle after no read
    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 32'd0));

    for (genvar c = 0; c < NCORES; c++) begin : g_c
        // R4: status flags agree with the interrupt line
        a_r4_prio_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
            ((|prio_word[c][2:0]) == core_irq[c]));

        // R2: set word leaves every written bit set
        a_r2_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == {5'd9, 5'(c)})
            |=> ((hmask[c] & $past(bus_wdata[NHWI-1:0])) == $past(bus_wdata[NHWI-1:0])));

        // R2: clear word leaves every written bit clear
        a_r2_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == {5'd10, 5'(c)})
            |=> ((hmask[c] & $past(bus_wdata[NHWI-1:0])) == '0));

        // R8: acknowledge without a same-cycle expiry clears the timer flag
        a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == {5'd3, 5'(c)}
             && !(tmr_period[c] != '0 && tmr_value[c] <= CNT_W'(1)))
            |=> !pti_pend[c]);

        // R7: a stopped timer does not move unless reprogrammed
        a_r7_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_period[c] == '0 && !(bus_wr && bus_addr == {5'd1, 5'(c)}))
            |=> $stable(tmr_value[c]));
    end

    for (genvar n = 0; n < NWTI; n++) begin : g_n
        // R6: a mailbox write leaves that mailbox pending
        a_r6_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == {5'd0, 5'(n)}) |=> wti_pend[n]);
    end
endmodule

bind irq_concentrator irq_conc_chk #(
    .NCORES(NCORES), .NHWI(NHWI), .NWTI(NWTI), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .core_irq  (core_irq),
    .hmask     (hmask_q),
    .wti_pend  (wti_pend),
    .pti_pend  (pti_pend),
    .prio_word (prio_word),
    .tmr_period(tmr_period),
    .tmr_value (tmr_value)
);

// File: tb/tb_irq_concentrator.sv
// Self-checking bench: sweeps masks, all hardware line patterns, mailboxes
// and timer timing on the default configuration (4 cores, 8 lines, 8 boxes).
module tb_irq_concentrator;
    localparam int NC = 4;
    localparam int NH = 8;
    localparam int NW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NH-1:0] hw_irq = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] core_irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_concentrator #(.NCORES(NC), .NHWI(NH), .NWTI(NW), .CNT_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_irq(core_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input int f, input int i, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = {5'(f), 5'(i)}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int f, input int i, output logic [31:0] q);
        bus_rd = 1'b1; bus_addr = {5'(f), 5'(i)};
        @(negedge clk);
        bus_rd = 1'b0;
        q = bus_rdata;
    endtask

    function automatic logic [31:0] lowest(input logic [31:0] v);
        logic [31:0] r = 0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = 32'(i);
        return r;
    endfunction

    function automatic logic [7:0] hpat(input int c);
        case (c)
            0: return 8'hFF;
            1: return 8'hF0;
            2: return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] q;
        logic [31:0] a, b, wm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 irq after reset", 32'(core_irq), 32'd0);
        check("R10 rdata after reset", bus_rdata, 32'd0);
        for (int c = 0; c < NC; c++) begin
            rd(4, c, q);  check("R10 timer mask", q, 0);
            rd(8, c, q);  check("R10 hw mask", q, 0);
            rd(12, c, q); check("R10 box mask", q, 0);
            rd(1, c, q);  check("R10 period", q, 0);
            rd(2, c, q);  check("R10 value", q, 0);
        end
        rd(6, 0, q);  check("R10 timer raw", q, 0);
        rd(14, 0, q); check("R10 box raw", q, 0);

        // R5: configuration word
        rd(16, 0, q); check("R5 config", q, 32'h0008_0804);

        // R1 / R11: unused codes and out-of-range core index read zero
        rd(7, 0, q);  check("R11 unused code 7", q, 0);
        rd(31, 3, q); check("R11 unused code 31", q, 0);
        rd(16, 0, q); @(negedge clk); check("R11 rdata clears after read", bus_rdata, 0);
        wr(9, 0, 32'hFF);
        rd(8, 5, q);  check("R1 core index beyond NCORES", q, 0);
        wr(10, 0, 32'hFF);

        // R2: set/clear sweep over classes and cores
        for (int k = 0; k < 3; k++) begin
            int base;
            base = 4 * (k + 1);
            wm = (k == 0) ? 32'h0F : 32'hFF;
            for (int c = 0; c < NC; c++) begin
                a = (32'h5A ^ 32'(c * 8'h13)) & wm;
                b = (32'h33 << c) & wm;
                wr(base + 1, c, a);
                rd(base, c, q); check("R2 set word", q, a);
                wr(base + 2, c, b);
                rd(base, c, q); check("R2 clear word", q, a & ~b);
            end
            for (int c = 0; c < NC; c++) begin
                a = (32'h5A ^ 32'(c * 8'h13)) & wm;
                b = (32'h33 << c) & wm;
                rd(base, c, q); check("R2 other cores untouched", q, a & ~b);
                wr(base + 2, c, 32'hFF);
            end
        end
        check("R3 no source no irq", 32'(core_irq), 0);

        // R3/R4/R9: exhaustive hardware line sweep
        for (int c = 0; c < NC; c++) wr(9, c, 32'(hpat(c)));
        for (int v = 0; v < 256; v++) begin
            logic [3:0] ei;
            hw_irq = 8'(v);
            #1;
            for (int c = 0; c < NC; c++) ei[c] = |(8'(v) & hpat(c));
            check("R3 irq lines for hw pattern", 32'(core_irq), 32'(ei));
            @(negedge clk);
            rd(10, 0, q); check("R9 raw hw bitmap", q, 32'(v));
            for (int c = 0; c < NC; c++) begin
                logic [31:0] m;
                m = 32'(8'(v) & hpat(c));
                rd(15, c, q);
                check("R4 hw status word", q, (m != 0) ? ((lowest(m) << 16) | 32'h2) : 32'h0);
            end
        end
        hw_irq = '0;
        for (int c = 0; c < NC; c++) wr(10, c, 32'hFF);

        // R6: mailboxes
        wr(13, 2, 32'hFF);
        wr(13, 0, 32'h0C);
        for (int n = 0; n < NW; n++) begin
            wr(0, n, 32'h1000 + 32'(n * 3));
            rd(14, 0, q); check("R6 write sets pending", q, (32'd1 << (n + 1)) - 1);
        end
        rd(15, 2, q); check("R4 box status lowest", q, 32'h4);
        for (int n = 0; n < NW; n++) begin
            logic [31:0] rem;
            rd(0, n, q); check("R6 mailbox data", q, 32'h1000 + 32'(n * 3));
            rem = ((32'd1 << NW) - 1) & ~((32'd1 << (n + 1)) - 1);
            rd(15, 2, q);
            check("R6 read clears, R4 next lowest", q, (rem != 0) ? ((lowest(rem) << 24) | 32'h4) : 0);
            check("R3 core0 box irq", 32'(core_irq[0]), 32'((rem & 32'h0C) != 0));
        end
        wr(0, 9, 32'hDEAD);
        rd(14, 0, q); check("R6 out-of-range box ignored", q, 0);
        wr(0, 3, 32'hAAAA);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = {5'd0, 5'd3}; bus_wdata = 32'hBBBB;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R6 same-cycle read returns old data", bus_rdata, 32'hAAAA);
        rd(14, 0, q); check("R6 same-cycle write keeps pending", q, 32'h8);
        rd(0, 3, q);  check("R6 new data stored", q, 32'hBBBB);
        rd(14, 0, q); check("R6 cleared after read", q, 0);
        wr(14, 2, 32'hFF);
        wr(14, 0, 32'hFF);

        // R7/R8: timer of core 1, period 5
        wr(5, 1, 32'h2);
        wr(1, 1, 32'd5);
        repeat (4) @(negedge clk);
        check("R7 no fire before period", 32'(core_irq), 0);
        @(negedge clk);
        check("R7 fires after period", 32'(core_irq), 32'h2);
        rd(3, 1, q);
        check("R8 ack clears", 32'(core_irq), 0);
        repeat (3) @(negedge clk);
        check("R7 second interval quiet", 32'(core_irq), 0);
        @(negedge clk);
        check("R7 second fire", 32'(core_irq), 32'h2);
        repeat (4) @(negedge clk);
        rd(3, 1, q);
        check("R8 fire beats same-cycle ack", 32'(core_irq), 32'h2);
        rd(2, 1, q);  check("R7 value reloaded", q, 32'd5);
        rd(1, 1, q);  check("R7 period reads back", q, 32'd5);
        rd(6, 0, q);  check("R9 raw timer bitmap", q, 32'h2);
        rd(15, 1, q); check("R4 timer status", q, 32'h0000_0101);
        wr(1, 1, 32'd0);
        rd(3, 1, q);
        repeat (20) @(negedge clk);
        check("R7 period 0 stops", 32'(core_irq), 0);
        rd(2, 1, q);  check("R7 stopped value", q, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule